// File: doc/BRIEF.md
# Instruction byte sequencer for a prefixed 8-bit bus monitor

The sequencer sits after a bus monitor that reports each finished bus cycle as one record: a kind code and the data byte seen on the bus. It regroups that stream into instructions. It follows the prefix grammar, including chained index prefixes and the indexed bit-operation form, where a displacement byte comes before the opcode. It then collects post-opcode displacement and immediate bytes, and finally the operand bytes moved by the instruction's own read and write cycles.

Per-opcode attributes are not stored inside the block. A combinational lookup port receives the prefix word in force and the opcode byte. In the same cycle it returns whether the entry exists, the displacement count, the immediate count, the read and write operand byte counts, a big-endian flag for the write operand and a repeat flag for block moves. Every finished item leaves as a one-cycle pulse with a kind code. The record fields are valid only during that pulse.

Top module: `instr_byte_seq`

## Requirements
- R1: Cycle kind codes on the input are 1 fetch, 2 memory read, 3 memory write, 4 I/O read, 5 I/O write, 6 interrupt acknowledge. While idle, every record other than a fetch is dropped without output, and a fetch begins a new instruction.
- R2: A first fetched byte of 0xCB, 0xED, 0xDD or 0xFD is held as a prefix, with prefix word 0x00nn. Any other first byte is the opcode, with prefix word 0x0000.
- R3: After a 0xDD or 0xFD prefix, a fetched 0xDD, 0xED or 0xFD replaces the held prefix. After a 0xCB or 0xED prefix, the next fetched byte is always the opcode.
- R4: After 0xDD or 0xFD, a fetched 0xCB gives prefix word {first prefix, 0xCB}. The next record must be a memory read and carries the displacement. The record after that must also be a memory read and carries the opcode.
- R5: Error codes are 1 (prefix not followed by a fetch), 2 (missing displacement read) and 3 (missing opcode read). Each one emits an error record and returns to idle, and the offending record is consumed.
- R6: An opcode whose lookup reports no entry emits error code 4 and returns to idle.
- R7: Displacements leave sign-extended to 16 bits. A displacement is 0 when the instruction has none. Immediates of 1 or 2 bytes are assembled low byte first, and are 0 when absent. Post-opcode displacement and immediate bytes are taken from records of any kind.
- R8: Output kind codes are 1 instruction, 2 read operand, 3 write operand, 4 error. The instruction record (prefix, opcode, displacement, immediate) pulses one cycle after the record holding its last opcode, displacement or immediate byte.
- R9: Read operand bytes are taken only from memory-read or I/O-read cycles, and write operand bytes only from memory-write or I/O-write cycles. Operands of 1 or 2 bytes are assembled low byte first. An operand record pulses one cycle after its last byte. Other records in the operand phase are ignored.
- R10: A 2-byte write operand flagged big-endian takes its first byte as the high byte.
- R11: With the repeat flag set, a read arriving after the read operand is complete starts a new read operand and re-arms the write operand.
- R12: The operand phase ends at idle once all counts are met without repeat. A fetch at any point in the operand phase starts a new instruction.
- R13: The lookup opcode equals the incoming data byte. The lookup prefix is the prefix word in force, and is 0 while idle or in the operand phase.
- R14: After reset no record is pulsed and the kind output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_valid | input | 1 | A finished bus cycle record is present |
| cyc_kind | input | 3 | Kind code of that cycle |
| cyc_data | input | 8 | Data byte of that cycle |
| lk_prefix | output | 16 | Prefix word for the attribute lookup |
| lk_opcode | output | 8 | Opcode byte for the attribute lookup |
| lk_valid | input | 1 | Lookup entry exists |
| lk_disp | input | 1 | Opcode is followed by one displacement byte |
| lk_imm_cnt | input | 2 | Immediate byte count, 0 to 2 |
| lk_rd_cnt | input | 2 | Read operand byte count, 0 to 2 |
| lk_wr_cnt | input | 2 | Write operand byte count, 0 to 2 |
| lk_wr_be | input | 1 | Two-byte write operand arrives high byte first |
| lk_repeat | input | 1 | Block-repeat instruction |
| rec_valid | output | 1 | One-cycle record pulse |
| rec_kind | output | 3 | Record kind code |
| rec_err | output | 3 | Error code, 0 when not an error |
| rec_prefix | output | 16 | Prefix word of the instruction |
| rec_opcode | output | 8 | Opcode byte |
| rec_disp | output | 16 | Sign-extended displacement |
| rec_imm | output | 16 | Immediate value |
| rec_operand | output | 16 | Read or write operand value |

## Verification
The assertions assume that the lookup answers in the same cycle and depends only on lk_prefix and lk_opcode. They also assume that every count it returns is at most 2, and that cyc_kind carries only the listed codes. The bench keeps within this by answering the lookup from a small fixed table, in which each entry has counts of 0, 1 or 2. It also drives only defined kind codes, at most one record per cycle, with idle cycles mixed in. Record order is checked against a behavioural model on every clock, so a missing, early or extra pulse is caught in the cycle where it appears.

// File: rtl/iseq_pkg.sv
// Shared widths, byte codes and enumerations of the instruction byte sequencer.
// Assumes bus data is one byte and records are at most two bytes wide.
package iseq_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int CODE_W = 3;
    localparam int CNT_W  = 2;

    localparam logic [BYTE_W-1:0] PFX_BITOP = 8'hCB;
    localparam logic [BYTE_W-1:0] PFX_EXT   = 8'hED;
    localparam logic [BYTE_W-1:0] PFX_IDX0  = 8'hDD;
    localparam logic [BYTE_W-1:0] PFX_IDX1  = 8'hFD;

    typedef enum logic [CODE_W-1:0] {
        CK_NONE = 3'd0, CK_FETCH = 3'd1, CK_MEMRD = 3'd2, CK_MEMWR = 3'd3,
        CK_IORD = 3'd4, CK_IOWR = 3'd5, CK_INTACK = 3'd6
    } cyc_kind_e;

    typedef enum logic [CODE_W-1:0] {
        RK_NONE = 3'd0, RK_INSTR = 3'd1, RK_READ = 3'd2, RK_WRITE = 3'd3, RK_ERROR = 3'd4
    } rec_kind_e;

    typedef enum logic [CODE_W-1:0] {
        ER_NONE = 3'd0, ER_PFX_NOFETCH = 3'd1, ER_NO_DISP = 3'd2,
        ER_NO_OPC = 3'd3, ER_BAD_OP = 3'd4
    } err_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PFX, ST_XDISP, ST_XOPC, ST_DISP, ST_IMM_LO, ST_IMM_HI, ST_OPND
    } seq_state_e;
endpackage

// File: rtl/iseq_cycle_cls.sv
// Cycle classifier: turns a kind code and data byte into the flags the
// sequencer branches on. Purely combinational; assumes kind codes from iseq_pkg.
module iseq_cycle_cls
    import iseq_pkg::*;
(
    input  logic [CODE_W-1:0] kind,
    input  logic [BYTE_W-1:0] data,
    output logic              is_fetch,
    output logic              is_rd,
    output logic              is_wr,
    output logic              is_memrd,
    output logic              lead_pfx,
    output logic              chain_pfx,
    output logic              bitop_pfx
);
    // Decode the cycle kind into direction flags.
    always_comb begin
        is_fetch = (kind == CK_FETCH);
        is_memrd = (kind == CK_MEMRD);
        is_rd    = (kind == CK_MEMRD) || (kind == CK_IORD);
        is_wr    = (kind == CK_MEMWR) || (kind == CK_IOWR);
    end

    // Recognise the prefix byte values.
    always_comb begin
        bitop_pfx = (data == PFX_BITOP);
        chain_pfx = (data == PFX_EXT) || (data == PFX_IDX0) || (data == PFX_IDX1);
        lead_pfx  = bitop_pfx || chain_pfx;
    end
endmodule

// File: rtl/iseq_byte_acc.sv
// Two-byte accumulator: collects one or two bytes into a word in either
// byte order. The caller marks the first byte; a lone byte lands low unless
// big-endian is requested. Assumes at most two loads per value.
module iseq_byte_acc #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ld,
    input  logic          first,
    input  logic          be,
    input  logic [BW-1:0] din,
    output logic [2*BW-1:0] q
);
    logic [2*BW-1:0] nxt;

    // Merge the incoming byte into the held word.
    always_comb begin
        if (first)
            nxt = be ? {din, {BW{1'b0}}} : {{BW{1'b0}}, din};
        else
            nxt = be ? {q[2*BW-1:BW], din} : {din, q[BW-1:0]};
    end

    // Hold the assembled word.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (clr)   q <= '0;
        else if (ld)    q <= nxt;
    end

    // R7
    acc_low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !clr && first && !be) |=> (q[2*BW-1:BW] == '0 && q[BW-1:0] == $past(din)));

    // R10
    acc_be_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !clr && !first && be) |=>
            (q[2*BW-1:BW] == $past(q[2*BW-1:BW]) && q[BW-1:0] == $past(din)));
endmodule

// File: rtl/instr_byte_seq.sv
// Instruction byte sequencer: consumes finished bus-cycle records, follows
// the prefix grammar, collects displacement, immediate and operand bytes, and
// pulses one record per instruction, operand or error. Assumes a combinational
// attribute lookup with counts of at most two and one record per clock.
module instr_byte_seq
    import iseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic [CODE_W-1:0] cyc_kind,
    input  logic [BYTE_W-1:0] cyc_data,
    output logic [WORD_W-1:0] lk_prefix,
    output logic [BYTE_W-1:0] lk_opcode,
    input  logic              lk_valid,
    input  logic              lk_disp,
    input  logic [CNT_W-1:0]  lk_imm_cnt,
    input  logic [CNT_W-1:0]  lk_rd_cnt,
    input  logic [CNT_W-1:0]  lk_wr_cnt,
    input  logic              lk_wr_be,
    input  logic              lk_repeat,
    output logic              rec_valid,
    output logic [CODE_W-1:0] rec_kind,
    output logic [CODE_W-1:0] rec_err,
    output logic [WORD_W-1:0] rec_prefix,
    output logic [BYTE_W-1:0] rec_opcode,
    output logic [WORD_W-1:0] rec_disp,
    output logic [WORD_W-1:0] rec_imm,
    output logic [WORD_W-1:0] rec_operand
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    seq_state_e        st, nx;
    logic [WORD_W-1:0] pfx_q, nx_pfx, disp_q, nx_disp;
    logic [BYTE_W-1:0] opc_q, nx_opc;
    logic [CNT_W-1:0]  a_imm, a_rd, a_wr, nx_imm, nx_rd, nx_wr;
    logic              a_be, a_rep, nx_be, nx_rep;
    logic [CNT_W-1:0]  rd_got, wr_got, nx_rdg, nx_wrg;
    rec_kind_e         emit, rec_kind_q;
    err_e              err, rec_err_q;
    logic              rec_valid_q;

    logic is_fetch, is_rd, is_wr, is_memrd, lead_pfx, chain_pfx, bitop_pfx;
    logic fetch_in, rd_in, wr_in, memrd_in, pfx_is_idx;
    logic start_fetch, opc_hit, finish_hdr;
    logic imm_clr, imm_ld, imm_first, rd_ld, rd_first, wr_ld, wr_first;
    logic [WORD_W-1:0] imm_q, rd_q, wr_q;

    iseq_cycle_cls u_cls (
        .kind(cyc_kind), .data(cyc_data), .is_fetch(is_fetch), .is_rd(is_rd),
        .is_wr(is_wr), .is_memrd(is_memrd), .lead_pfx(lead_pfx),
        .chain_pfx(chain_pfx), .bitop_pfx(bitop_pfx)
    );

    // Gate cycle flags with the record strobe and classify the held prefix.
    always_comb begin
        fetch_in   = cyc_valid && is_fetch;
        rd_in      = cyc_valid && is_rd;
        wr_in      = cyc_valid && is_wr;
        memrd_in   = cyc_valid && is_memrd;
        pfx_is_idx = (pfx_q[BYTE_W-1:0] == PFX_IDX0) || (pfx_q[BYTE_W-1:0] == PFX_IDX1);
    end

    // Present the prefix in force and the incoming byte to the lookup.
    always_comb begin
        lk_prefix = (st == ST_IDLE || st == ST_OPND) ? '0 : pfx_q;
        lk_opcode = cyc_data;
    end

    // Next-state, capture and record decisions for one incoming record.
    always_comb begin
        nx = st; nx_pfx = pfx_q; nx_opc = opc_q; nx_disp = disp_q;
        nx_imm = a_imm; nx_rd = a_rd; nx_wr = a_wr; nx_be = a_be; nx_rep = a_rep;
        nx_rdg = rd_got; nx_wrg = wr_got;
        emit = RK_NONE; err = ER_NONE;
        start_fetch = 1'b0; opc_hit = 1'b0; finish_hdr = 1'b0;
        imm_clr = 1'b0; imm_ld = 1'b0; imm_first = 1'b0;
        rd_ld = 1'b0; rd_first = 1'b0; wr_ld = 1'b0; wr_first = 1'b0;
        if (cyc_valid) begin
            unique case (st)
                ST_IDLE: start_fetch = is_fetch;
                ST_PFX: begin
                    if (!is_fetch) begin
                        emit = RK_ERROR; err = ER_PFX_NOFETCH; nx = ST_IDLE;
                    end else if (pfx_is_idx && bitop_pfx) begin
                        nx_pfx = {pfx_q[BYTE_W-1:0], cyc_data}; nx = ST_XDISP;
                    end else if (pfx_is_idx && chain_pfx) begin
                        nx_pfx = {{BYTE_W{1'b0}}, cyc_data};
                    end else begin
                        opc_hit = 1'b1;
                    end
                end
                ST_XDISP: begin
                    if (memrd_in) begin
                        nx_disp = {{BYTE_W{cyc_data[BYTE_W-1]}}, cyc_data}; nx = ST_XOPC;
                    end else begin
                        emit = RK_ERROR; err = ER_NO_DISP; nx = ST_IDLE;
                    end
                end
                ST_XOPC: begin
                    if (memrd_in) opc_hit = 1'b1;
                    else begin emit = RK_ERROR; err = ER_NO_OPC; nx = ST_IDLE; end
                end
                ST_DISP: begin
                    nx_disp = {{BYTE_W{cyc_data[BYTE_W-1]}}, cyc_data};
                    if (a_imm != '0) nx = ST_IMM_LO;
                    else finish_hdr = 1'b1;
                end
                ST_IMM_LO: begin
                    imm_ld = 1'b1; imm_first = 1'b1;
                    if (a_imm == TWO) nx = ST_IMM_HI;
                    else finish_hdr = 1'b1;
                end
                ST_IMM_HI: begin
                    imm_ld = 1'b1; finish_hdr = 1'b1;
                end
                ST_OPND: begin
                    if (fetch_in) begin
                        start_fetch = 1'b1;
                    end else begin
                        if (rd_in) begin
                            if (rd_got < a_rd) begin
                                rd_ld = 1'b1; rd_first = (rd_got == '0);
                                nx_rdg = rd_got + ONE;
                                if (nx_rdg == a_rd) emit = RK_READ;
                            end else if (a_rep && a_rd != '0) begin
                                rd_ld = 1'b1; rd_first = 1'b1; nx_rdg = ONE; nx_wrg = '0;
                                if (a_rd == ONE) emit = RK_READ;
                            end
                        end else if (wr_in) begin
                            if (wr_got < a_wr) begin
                                wr_ld = 1'b1; wr_first = (wr_got == '0);
                                nx_wrg = wr_got + ONE;
                                if (nx_wrg == a_wr) emit = RK_WRITE;
                            end
                        end
                        if (nx_rdg == a_rd && nx_wrg == a_wr && !a_rep) nx = ST_IDLE;
                    end
                end
                default: nx = ST_IDLE;
            endcase
        end
        if (start_fetch) begin
            if (lead_pfx) begin
                nx_pfx = {{BYTE_W{1'b0}}, cyc_data}; nx = ST_PFX;
            end else begin
                nx_pfx = '0; opc_hit = 1'b1;
            end
        end
        if (opc_hit) begin
            nx_opc = cyc_data; imm_clr = 1'b1;
            nx_disp = (st == ST_XOPC) ? disp_q : '0;
            nx_imm = lk_imm_cnt; nx_rd = lk_rd_cnt; nx_wr = lk_wr_cnt;
            nx_be = lk_wr_be; nx_rep = lk_repeat;
            if (!lk_valid) begin
                emit = RK_ERROR; err = ER_BAD_OP; nx = ST_IDLE;
            end else if (lk_disp) nx = ST_DISP;
            else if (lk_imm_cnt != '0) nx = ST_IMM_LO;
            else finish_hdr = 1'b1;
        end
        if (finish_hdr) begin
            emit = RK_INSTR; nx_rdg = '0; nx_wrg = '0;
            nx = (nx_rd == '0 && nx_wr == '0) ? ST_IDLE : ST_OPND;
        end
    end

    // Register state, instruction fields and the record pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; pfx_q <= '0; opc_q <= '0; disp_q <= '0;
            a_imm <= '0; a_rd <= '0; a_wr <= '0; a_be <= 1'b0; a_rep <= 1'b0;
            rd_got <= '0; wr_got <= '0;
            rec_valid_q <= 1'b0; rec_kind_q <= RK_NONE; rec_err_q <= ER_NONE;
        end else begin
            st <= nx; pfx_q <= nx_pfx; opc_q <= nx_opc; disp_q <= nx_disp;
            a_imm <= nx_imm; a_rd <= nx_rd; a_wr <= nx_wr; a_be <= nx_be; a_rep <= nx_rep;
            rd_got <= nx_rdg; wr_got <= nx_wrg;
            rec_valid_q <= (emit != RK_NONE); rec_kind_q <= emit; rec_err_q <= err;
        end
    end

    iseq_byte_acc #(.BW(BYTE_W)) u_imm (
        .clk(clk), .rst_n(rst_n), .clr(imm_clr), .ld(imm_ld), .first(imm_first),
        .be(1'b0), .din(cyc_data), .q(imm_q)
    );
    iseq_byte_acc #(.BW(BYTE_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .ld(rd_ld), .first(rd_first),
        .be(1'b0), .din(cyc_data), .q(rd_q)
    );
    iseq_byte_acc #(.BW(BYTE_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .ld(wr_ld), .first(wr_first),
        .be(a_be && (a_wr == TWO)), .din(cyc_data), .q(wr_q)
    );

    // Drive the record outputs from the held fields.
    always_comb begin
        rec_valid   = rec_valid_q;
        rec_kind    = rec_kind_q;
        rec_err     = rec_err_q;
        rec_prefix  = pfx_q;
        rec_opcode  = opc_q;
        rec_disp    = disp_q;
        rec_imm     = imm_q;
        rec_operand = (rec_kind_q == RK_WRITE) ? wr_q : rd_q;
    end

    // R1
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && cyc_valid && !is_fetch) |=> (!rec_valid_q && st == ST_IDLE));

    // R5
    err_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid_q && rec_kind_q == RK_ERROR) |-> (st == ST_IDLE && rec_err_q != ER_NONE));

    // R4
    xcb_pfx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_XDISP || st == ST_XOPC) |->
            (pfx_q[BYTE_W-1:0] == PFX_BITOP &&
             (pfx_q[WORD_W-1:BYTE_W] == PFX_IDX0 || pfx_q[WORD_W-1:BYTE_W] == PFX_IDX1)));

    // R9
    rd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid_q && rec_kind_q == RK_READ) |-> $past(cyc_valid && is_rd));

    // R9
    wr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid_q && rec_kind_q == RK_WRITE) |-> $past(cyc_valid && is_wr));
endmodule

// File: tb/tb_instr_byte_seq.sv
module tb_instr_byte_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cyc_valid = 1'b0;
    logic [2:0] cyc_kind = '0;
    logic [7:0] cyc_data = '0;
    logic [15:0] lk_prefix;
    logic [7:0]  lk_opcode;
    logic lk_valid, lk_disp, lk_wr_be, lk_repeat;
    logic [1:0] lk_imm_cnt, lk_rd_cnt, lk_wr_cnt;
    logic rec_valid;
    logic [2:0] rec_kind, rec_err;
    logic [15:0] rec_prefix, rec_disp, rec_imm, rec_operand;
    logic [7:0] rec_opcode;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    instr_byte_seq dut (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind),
        .cyc_data(cyc_data), .lk_prefix(lk_prefix), .lk_opcode(lk_opcode),
        .lk_valid(lk_valid), .lk_disp(lk_disp), .lk_imm_cnt(lk_imm_cnt),
        .lk_rd_cnt(lk_rd_cnt), .lk_wr_cnt(lk_wr_cnt), .lk_wr_be(lk_wr_be),
        .lk_repeat(lk_repeat), .rec_valid(rec_valid), .rec_kind(rec_kind),
        .rec_err(rec_err), .rec_prefix(rec_prefix), .rec_opcode(rec_opcode),
        .rec_disp(rec_disp), .rec_imm(rec_imm), .rec_operand(rec_operand)
    );

    // attribute bits: {ok, dis, imm[1:0], rd[1:0], wr[1:0], be, rep}
    function automatic logic [9:0] mk(int dis, int imm, int rd, int wr, int be, int rep);
        return {1'b1, dis[0], imm[1:0], rd[1:0], wr[1:0], be[0], rep[0]};
    endfunction

    function automatic logic [9:0] tbl(logic [15:0] p, logic [7:0] o);
        case ({p, o})
            24'h000000: return mk(0, 0, 0, 0, 0, 0);
            24'h00003E: return mk(0, 1, 0, 0, 0, 0);
            24'h000021: return mk(0, 2, 0, 0, 0, 0);
            24'h00007E: return mk(0, 0, 1, 0, 0, 0);
            24'h000077: return mk(0, 0, 0, 1, 0, 0);
            24'h000022: return mk(0, 2, 0, 2, 0, 0);
            24'h0000C5: return mk(0, 0, 0, 2, 1, 0);
            24'h00002A: return mk(0, 2, 2, 0, 0, 0);
            24'h00EDB0: return mk(0, 0, 1, 1, 0, 1);
            24'h00DD7E: return mk(1, 0, 1, 0, 0, 0);
            24'h00DD36: return mk(1, 1, 0, 1, 0, 0);
            24'hDDCB46, 24'hFDCB46: return mk(0, 0, 1, 0, 0, 0);
            24'hDDCBC6, 24'hFDCBC6: return mk(0, 0, 1, 1, 0, 0);
            24'h00CB47: return mk(0, 0, 0, 0, 0, 0);
            24'h00FD21: return mk(0, 2, 0, 0, 0, 0);
            default:    return 10'd0;
        endcase
    endfunction

    always_comb
        {lk_valid, lk_disp, lk_imm_cnt, lk_rd_cnt, lk_wr_cnt, lk_wr_be, lk_repeat} =
            tbl(lk_prefix, lk_opcode);

    // reference model state
    int m_ph = 0;                 // 0 idle,1 prefix,2 xdisp,3 xopcode,4 disp,5 imm lo,6 imm hi,7 operands
    int m_pfx = 0, m_opc = 0, m_disp = 0, m_imm = 0, m_rdv = 0, m_wrv = 0, m_rdn = 0, m_wrn = 0;
    logic [9:0] m_att = '0;
    bit e_v = 0;
    int e_kind = 0, e_err = 0, e_pfx = 0, e_opc = 0, e_disp = 0, e_imm = 0, e_opnd = 0;
    string e_req = "R14", e_tag = "R8";

    task automatic fail_line(string req, logic [63:0] act, logic [63:0] exp);
        n_fail++;
        $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    endtask

    task automatic expect_err(int code, string req);
        e_v = 1; e_kind = 4; e_err = code; e_tag = req; m_ph = 0;
    endtask

    task automatic header_done(string req);
        e_v = 1; e_kind = 1; e_tag = req;
        e_pfx = m_pfx; e_opc = m_opc; e_disp = m_disp; e_imm = m_imm;
        m_rdn = 0; m_wrn = 0;
        m_ph = (m_att[5:4] == 0 && m_att[3:2] == 0) ? 0 : 7;
    endtask

    task automatic take_opcode(int d, string req);
        m_att = tbl(m_pfx[15:0], d[7:0]);
        m_opc = d;
        if (m_ph != 3) m_disp = 0;
        m_imm = 0;
        if (!m_att[9]) expect_err(4, "R6");
        else if (m_att[8]) m_ph = 4;
        else if (m_att[7:6] != 0) m_ph = 5;
        else header_done(req);
    endtask

    task automatic model(bit v, int k, int d);
        bit fe, rdk, wrk;
        e_v = 0;
        e_req = (m_ph == 7) ? "R9" : "R1";
        if (!v) return;
        fe = (k == 1); rdk = (k == 2 || k == 4); wrk = (k == 3 || k == 5);
        if (m_ph == 0 || (m_ph == 7 && fe)) begin
            if (fe) begin
                if (d == 'hCB || d == 'hED || d == 'hDD || d == 'hFD) begin m_pfx = d; m_ph = 1; end
                else begin m_pfx = 0; m_ph = 0; take_opcode(d, "R2"); end
            end
        end else if (m_ph == 1) begin
            if (!fe) expect_err(1, "R5");
            else if ((m_pfx == 'hDD || m_pfx == 'hFD) && d == 'hCB) begin
                m_pfx = m_pfx * 256 + d; m_ph = 2;
            end else if ((m_pfx == 'hDD || m_pfx == 'hFD) && (d == 'hDD || d == 'hED || d == 'hFD))
                m_pfx = d;
            else take_opcode(d, "R3");
        end else if (m_ph == 2) begin
            if (k != 2) expect_err(2, "R5");
            else begin m_disp = (d >= 128) ? (d + 'hFF00) : d; m_ph = 3; end
        end else if (m_ph == 3) begin
            if (k != 2) expect_err(3, "R5");
            else take_opcode(d, "R4");
        end else if (m_ph == 4) begin
            m_disp = (d >= 128) ? (d + 'hFF00) : d;
            if (m_att[7:6] != 0) m_ph = 5; else header_done("R7");
        end else if (m_ph == 5) begin
            m_imm = d;
            if (m_att[7:6] == 2) m_ph = 6; else header_done("R7");
        end else if (m_ph == 6) begin
            m_imm = m_imm + d * 256; header_done("R7");
        end else begin
            if (rdk) begin
                if (m_rdn < int'(m_att[5:4])) begin
                    m_rdv = (m_rdn == 0) ? d : (m_rdv + d * 256);
                    m_rdn++;
                    if (m_rdn == int'(m_att[5:4])) begin e_v = 1; e_kind = 2; e_opnd = m_rdv; e_tag = "R9"; end
                end else if (m_att[0] && m_att[5:4] != 0) begin
                    m_rdv = d; m_rdn = 1; m_wrn = 0;
                    if (m_att[5:4] == 1) begin e_v = 1; e_kind = 2; e_opnd = m_rdv; e_tag = "R11"; end
                end
            end else if (wrk) begin
                if (m_wrn < int'(m_att[3:2])) begin
                    if (m_att[1] && m_att[3:2] == 2)
                        m_wrv = (m_wrn == 0) ? d * 256 : (m_wrv + d);
                    else
                        m_wrv = (m_wrn == 0) ? d : (m_wrv + d * 256);
                    m_wrn++;
                    if (m_wrn == int'(m_att[3:2])) begin
                        e_v = 1; e_kind = 3; e_opnd = m_wrv;
                        e_tag = (m_att[1] && m_att[3:2] == 2) ? "R10" : "R9";
                    end
                end
            end
            if (m_rdn == int'(m_att[5:4]) && m_wrn == int'(m_att[3:2]) && !m_att[0]) m_ph = 0;
        end
    endtask

    task automatic compare();
        logic [63:0] a, x;
        n_chk++;
        if (rec_valid !== e_v) begin
            fail_line(e_v ? e_tag : e_req, {63'd0, rec_valid}, {63'd0, e_v});
            return;
        end
        if (!e_v) return;
        case (e_kind)
            1: begin
                a = {5'd0, rec_kind, rec_prefix, rec_opcode, rec_disp, rec_imm};
                x = {5'd0, 3'd1, e_pfx[15:0], e_opc[7:0], e_disp[15:0], e_imm[15:0]};
            end
            2, 3: begin
                a = {45'd0, rec_kind, rec_operand};
                x = {45'd0, e_kind[2:0], e_opnd[15:0]};
            end
            default: begin
                a = {58'd0, rec_kind, rec_err};
                x = {58'd0, 3'd4, e_err[2:0]};
            end
        endcase
        if (a !== x) fail_line(e_tag, a, x);
    endtask

    task automatic step(bit v, int k, int d);
        logic [15:0] xp;
        @(negedge clk);
        compare();
        cyc_valid = v; cyc_kind = k[2:0]; cyc_data = d[7:0];
        #1;
        if (v) begin
            xp = (m_ph == 0 || m_ph == 7) ? 16'h0 : m_pfx[15:0];
            n_chk++;
            if (lk_prefix !== xp || lk_opcode !== d[7:0])   // R13
                fail_line("R13", {40'd0, lk_prefix, lk_opcode}, {40'd0, xp, d[7:0]});
        end
        model(v, k, d);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        fail_line("watchdog", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;   // R14 reset state
        if (rec_valid !== 1'b0 || rec_kind !== 3'd0)
            fail_line("R14", {60'd0, rec_valid, rec_kind}, 64'd0);
        rst_n = 1'b1;
        // R1: non-fetch records ignored while idle
        step(1, 2, 'h11); step(1, 5, 'h22); step(1, 6, 'hFF); idle(2);
        // R2/R8: plain opcodes, immediates low byte first (R7)
        step(1, 1, 'h00);
        step(1, 1, 'h3E); step(1, 2, 'h85);
        step(1, 1, 'h21); step(1, 2, 'h34); step(1, 2, 'h12); idle(1);
        // R9: read operand; intack and writes ignored, trailing read ignored (R12)
        step(1, 1, 'h7E); step(1, 6, 'h00); step(1, 3, 'h44); step(1, 2, 'h5A); step(1, 2, 'h66);
        // R9: 2-byte little-endian write after 2-byte immediate
        step(1, 1, 'h22); step(1, 2, 'h00); step(1, 2, 'h40); step(1, 3, 'hCD); idle(1); step(1, 5, 'hAB);
        // R10: big-endian 2-byte write
        step(1, 1, 'hC5); step(1, 3, 'h12); step(1, 3, 'h34);
        // R9: 2-byte read from I/O read
        step(1, 1, 'h2A); step(1, 2, 'h01); step(1, 2, 'h02); step(1, 4, 'h78); step(1, 4, 'h56);
        // R11: repeat loop, then R12 fetch ends it
        step(1, 1, 'hED); step(1, 1, 'hB0); step(1, 2, 'h11); step(1, 3, 'h11);
        step(1, 2, 'h22); step(1, 3, 'h22); step(1, 2, 'h33); step(1, 1, 'h00);
        // R7: post-opcode displacement, negative
        step(1, 1, 'hDD); step(1, 1, 'h7E); step(1, 2, 'hFE); step(1, 2, 'h99);
        step(1, 1, 'hDD); step(1, 1, 'h36); step(1, 2, 'h05); step(1, 2, 'h77); step(1, 3, 'h77);
        // R4: indexed bit form
        step(1, 1, 'hDD); step(1, 1, 'hCB); step(1, 2, 'h80); step(1, 2, 'h46); step(1, 2, 'h01);
        step(1, 1, 'hFD); step(1, 1, 'hCB); step(1, 2, 'h10); step(1, 2, 'hC6);
        step(1, 2, 'h03); step(1, 3, 'h07);
        // R3: chained prefixes, last wins; bit prefix takes any opcode
        step(1, 1, 'hDD); step(1, 1, 'hDD); step(1, 1, 'hFD); step(1, 1, 'h21);
        step(1, 2, 'h00); step(1, 2, 'hC0);
        step(1, 1, 'hCB); step(1, 1, 'h47);
        step(1, 1, 'hED); step(1, 1, 'hDD);                    // R6 via ED then DD opcode
        // R5: the three grammar errors
        step(1, 1, 'hDD); step(1, 2, 'h00);
        step(1, 1, 'hDD); step(1, 1, 'hCB); step(1, 3, 'h00);
        step(1, 1, 'hFD); step(1, 1, 'hCB); step(1, 2, 'h05); step(1, 1, 'h46);
        // R6: unknown opcode
        step(1, 1, 'hFF);
        // R12: fetch while a write is pending starts a new instruction
        step(1, 1, 'h77); step(1, 1, 'h00); step(1, 3, 'h55);
        idle(3);
        finish_run();
    end
endmodule